// File: doc/BRIEF.md
# Five-stage pipelined integer datapath

An in-order integer core that splits every instruction into five steps (fetch, decode, execute, memory access and write-back), with a register stage between each pair. It holds its own program counter, a 32-entry register file, a word-indexed instruction memory and a data memory. It runs four register-register ALU operations, an add-immediate, a word load, a word store and an equality branch. There is no forwarding and there are no interlocks, so a program places two no-ops between an instruction and any instruction that reads its result.

The two memories are filled through a preload port while reset is held. After release, the core runs by itself. A debug bus shows the program counter and every register write as it retires. A test can therefore check a program's results against a sequential model of the instruction set.

A branch is resolved in the memory stage. The three instructions fetched after a taken branch are cancelled, so to software the branch behaves as a plain jump with no delay slots.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `dbg_pc` = 0 and `dbg_wb_we` = 0. Reset empties every stage and clears all registers to zero.
- R2: After reset is released, `dbg_pc` rises by 4 at each rising edge unless a branch redirects it. The write of the instruction at address 0 is visible on the debug bus after the fourth rising edge following release.
- R3: The opcode is instruction bits [31:26]: 0 no-op, 1 add, 2 sub, 3 and, 4 or, 5 add-immediate, 6 load, 7 store, 8 branch-if-equal. Any other value acts as a no-op and writes nothing.
- R4: Register-register operations read A from register bits [10:6] and B from register bits [15:11]. They write A op B to the register named by bits [20:16].
- R5: Add-immediate writes A plus the sign-extended bits [15:0] to the register named by bits [15:11].
- R6: Load and store use the byte address A plus the sign-extended bits [15:0]. The data word index is address bits [9:2]. A store writes B there. A load writes the word to the register named by bits [15:11].
- R7: Branch-if-equal is taken when A equals B. The target is the branch's own address plus the sign-extended bits [15:0]. The instruction index is address bits [9:2]. The three instructions fetched after a taken branch make no register or memory write.
- R8: A branch whose operands differ is not taken. The instructions after it run in order.
- R9: Register 0 always reads as zero, and a write to it leaves it zero.
- R10: A register written in write-back is seen by an instruction decoding in that same cycle. Two no-ops between producer and consumer are enough.
- R11: `dbg_wb_we`, `dbg_wb_rd` and `dbg_wb_data` show each retiring register write, one per cycle, in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Current fetch address |
| dbg_wb_we | output | 1 | A register write retires this cycle |
| dbg_wb_rd | output | 5 | Destination of the retiring write |
| dbg_wb_data | output | 32 | Value of the retiring write |

## Verification
The fetch address moves one rising edge after reset is released, and by 4 at every later edge. A register write reaches the debug bus four edges after its instruction was fetched. A taken branch changes the fetch address one edge after it reaches the memory stage, and the next three write-back slots stay empty. The bench releases reset just after a falling edge and counts rising edges from there. It samples only at falling edges and expects the first write at edge four and the address 12 at edge three. Each later write is compared in order against a sequential model of the program, and the total number of writes must match exactly.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN  = 32;
  localparam int RIDXW = 5;

  typedef enum logic [5:0] {
    OP_NOP   = 6'd0,
    OP_ADD   = 6'd1,
    OP_SUB   = 6'd2,
    OP_AND   = 6'd3,
    OP_OR    = 6'd4,
    OP_ADDI  = 6'd5,
    OP_LOAD  = 6'd6,
    OP_STORE = 6'd7,
    OP_BEQ   = 6'd8
  } opcode_e;

  typedef enum logic [1:0] {
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_OR
  } alu_fn_e;

  typedef struct packed {
    logic    use_imm;
    logic    pc_base;
    alu_fn_e fn;
    logic    reg_we;
    logic    is_load;
    logic    is_store;
    logic    is_branch;
  } ctrl_t;
endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] regs [NREG];
  logic          wr_live;

  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[waddr] <= wdata;
    end
  end

  // write-first: a read in the write cycle returns the incoming value
  always_comb begin
    if (raddr_a == '0)                  rdata_a = '0;
    else if (wr_live && waddr == raddr_a) rdata_a = wdata;
    else                                rdata_a = regs[raddr_a];
    if (raddr_b == '0)                  rdata_b = '0;
    else if (wr_live && waddr == raddr_b) rdata_b = wdata;
    else                                rdata_b = regs[raddr_b];
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
(
  input  alu_fn_e         fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [XLEN-1:0]  ir,
  output ctrl_t            ctrl,
  output logic [RIDXW-1:0] ra_idx,
  output logic [RIDXW-1:0] rb_idx,
  output logic [RIDXW-1:0] rd_idx,
  output logic [XLEN-1:0]  imm
);
  logic dst_hi;
  logic unused_bits;

  assign unused_bits = ^ir[25:21];
  assign ra_idx = ir[10:6];
  assign rb_idx = ir[15:11];
  assign imm    = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign rd_idx = dst_hi ? ir[20:16] : ir[15:11];

  always_comb begin
    ctrl   = '0;
    ctrl.fn = FN_ADD;
    dst_hi = 1'b0;
    case (ir[31:26])
      OP_ADD:   begin ctrl.reg_we = 1'b1; dst_hi = 1'b1; ctrl.fn = FN_ADD; end
      OP_SUB:   begin ctrl.reg_we = 1'b1; dst_hi = 1'b1; ctrl.fn = FN_SUB; end
      OP_AND:   begin ctrl.reg_we = 1'b1; dst_hi = 1'b1; ctrl.fn = FN_AND; end
      OP_OR:    begin ctrl.reg_we = 1'b1; dst_hi = 1'b1; ctrl.fn = FN_OR;  end
      OP_ADDI:  begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
      OP_LOAD:  begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.is_load = 1'b1; end
      OP_STORE: begin ctrl.use_imm = 1'b1; ctrl.is_store = 1'b1; end
      OP_BEQ:   begin ctrl.use_imm = 1'b1; ctrl.pc_base = 1'b1; ctrl.is_branch = 1'b1; end
      default:  ctrl = '0;
    endcase
  end
endmodule

// File: rtl/pipe5_dmem.sv
module pipe5_dmem #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata_q <= mem[addr];
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8,
  parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  output logic [31:0]      dbg_pc,
  output logic             dbg_wb_we,
  output logic [4:0]       dbg_wb_rd,
  output logic [31:0]      dbg_wb_data
);
  localparam int IMEM_DEPTH = 1 << IMEM_AW;

  // fetch
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic            ifid_v;
  logic [XLEN-1:0] ifid_ir, ifid_pc;

  // decode
  ctrl_t            dec_ctrl;
  logic [RIDXW-1:0] dec_ra, dec_rb, dec_rd;
  logic [XLEN-1:0]  dec_imm, rf_a, rf_b;
  logic             idex_v;
  ctrl_t            idex_ctrl;
  logic [XLEN-1:0]  idex_a, idex_b, idex_imm, idex_pc;
  logic [RIDXW-1:0] idex_rd;

  // execute
  logic [XLEN-1:0]  alu_a, alu_b, alu_y;
  logic             exmem_v, exmem_we, exmem_load, exmem_store, exmem_branch, exmem_take;
  logic [XLEN-1:0]  exmem_y, exmem_b;
  logic [RIDXW-1:0] exmem_rd;

  // memory
  logic             mem_redirect;
  logic             dm_we;
  logic [DMEM_AW-1:0] dm_addr;
  logic [XLEN-1:0]  dm_wdata, lmd_q;
  logic             memwb_we, memwb_load;
  logic [RIDXW-1:0] memwb_rd;
  logic [XLEN-1:0]  memwb_y, wb_data;

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IMEM_AW+2],
                         exmem_y[1:0], exmem_y[XLEN-1:DMEM_AW+2]};

  assign mem_redirect = exmem_v && exmem_branch && exmem_take;

  // ---------------- fetch ----------------
  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    ifid_ir <= imem[pc_q[IMEM_AW+1:2]];
    ifid_pc <= pc_q;
  end

  always_ff @(posedge clk) begin
    if (rst)               pc_q <= '0;
    else if (mem_redirect) pc_q <= exmem_y;
    else                   pc_q <= pc_q + XLEN'(4);
  end

  // ---------------- decode ----------------
  pipe5_decode u_dec (
    .ir     (ifid_ir),
    .ctrl   (dec_ctrl),
    .ra_idx (dec_ra),
    .rb_idx (dec_rb),
    .rd_idx (dec_rd),
    .imm    (dec_imm)
  );

  pipe5_regfile #(.NREG(32), .DW(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (memwb_we),
    .waddr   (memwb_rd),
    .wdata   (wb_data),
    .raddr_a (dec_ra),
    .raddr_b (dec_rb),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  always_ff @(posedge clk) begin
    idex_ctrl <= dec_ctrl;
    idex_a    <= rf_a;
    idex_b    <= rf_b;
    idex_imm  <= dec_imm;
    idex_rd   <= dec_rd;
    idex_pc   <= ifid_pc;
  end

  // ---------------- execute ----------------
  assign alu_a = idex_ctrl.pc_base ? idex_pc  : idex_a;
  assign alu_b = idex_ctrl.use_imm ? idex_imm : idex_b;

  pipe5_alu u_alu (
    .fn (idex_ctrl.fn),
    .a  (alu_a),
    .b  (alu_b),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    exmem_y      <= alu_y;
    exmem_b      <= idex_b;
    exmem_rd     <= idex_rd;
    exmem_we     <= idex_ctrl.reg_we;
    exmem_load   <= idex_ctrl.is_load;
    exmem_store  <= idex_ctrl.is_store;
    exmem_branch <= idex_ctrl.is_branch;
    exmem_take   <= (idex_a == idex_b);
  end

  // ---------------- memory ----------------
  assign dm_we    = ld_en ? ld_dmem : (exmem_v && exmem_store);
  assign dm_addr  = ld_en ? ld_addr[DMEM_AW-1:0] : exmem_y[DMEM_AW+1:2];
  assign dm_wdata = ld_en ? ld_data : exmem_b;

  pipe5_dmem #(.AW(DMEM_AW), .DW(XLEN)) u_dmem (
    .clk     (clk),
    .we      (dm_we),
    .addr    (dm_addr),
    .wdata   (dm_wdata),
    .rdata_q (lmd_q)
  );

  always_ff @(posedge clk) begin
    memwb_rd   <= exmem_rd;
    memwb_y    <= exmem_y;
    memwb_load <= exmem_load;
  end

  // ---------------- stage valids and flush ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ifid_v   <= 1'b0;
      idex_v   <= 1'b0;
      exmem_v  <= 1'b0;
      memwb_we <= 1'b0;
    end else begin
      ifid_v   <= !mem_redirect;
      idex_v   <= ifid_v  && !mem_redirect;
      exmem_v  <= idex_v  && !mem_redirect;
      memwb_we <= exmem_v && exmem_we;
    end
  end

  // ---------------- write-back ----------------
  assign wb_data = memwb_load ? lmd_q : memwb_y;

  assign dbg_pc      = pc_q;
  assign dbg_wb_we   = memwb_we;
  assign dbg_wb_rd   = memwb_rd;
  assign dbg_wb_data = wb_data;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        wb_we,
  input logic        redir,
  input logic        ifid_v,
  input logic        idex_v,
  input logic        exmem_v
);
  // R1: reset leaves fetch at address zero with no retiring write
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (pc == 32'd0) && !wb_we);

  // R2: sequential fetch advances by one word per cycle
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(redir)) |-> pc == $past(pc) + 32'd4);

  // R7: a taken branch empties the three younger stages
  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    redir |=> (!ifid_v && !idex_v && !exmem_v));

  // R7: the cancelled instructions never reach write-back
  p_quiet_wb_r7: assert property (@(posedge clk) disable iff (rst)
    redir |=> !wb_we ##1 !wb_we ##1 !wb_we);

  // R11: every retiring write came from a live memory-stage instruction
  p_wb_source_r11: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> $past(exmem_v));
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pc      (dbg_pc),
  .wb_we   (dbg_wb_we),
  .redir   (mem_redirect),
  .ifid_v  (ifid_v),
  .idex_v  (idex_v),
  .exmem_v (exmem_v)
);

// File: tb/pipe5_core_bench.sv
module pipe5_core_bench;
  localparam time CLK_P = 20ns;
  localparam int  WORDS = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] dbg_pc, dbg_wb_data;
  logic        dbg_wb_we;
  logic [4:0]  dbg_wb_rd;

  int checks = 0;
  int errors = 0;

  logic [31:0] prog  [WORDS];
  logic [31:0] dinit [WORDS];
  int          prog_n;
  logic [4:0]  exp_rd   [512];
  logic [31:0] exp_data [512];
  int          exp_n;
  int          first_wc;
  logic [31:0] pc_at3;

  always #(CLK_P/2) clk = ~clk;

  pipe5_core u_pipe5_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc),
    .dbg_wb_we(dbg_wb_we), .dbg_wb_rd(dbg_wb_rd), .dbg_wb_data(dbg_wb_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // encoders: opcode [31:26], dest-rr [20:16], B/dest-ri [15:11], A [10:6], imm [15:0]
  function automatic logic [31:0] rr(input logic [5:0] op, input logic [4:0] rd,
                                     input logic [4:0] ra, input logic [4:0] rb);
    return {op, 5'd0, rd, rb, ra, 6'd0};
  endfunction

  function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] r2,
                                     input logic [4:0] ra, input logic [5:0] low);
    return {op, 10'd0, r2, ra, low};
  endfunction

  localparam logic [31:0] HALT = 32'h2000_0000; // branch r0==r0, offset 0

  task automatic clear_prog();
    for (int i = 0; i < WORDS; i++) begin
      prog[i]  = 32'd0;
      dinit[i] = 32'h1000_0000 + 32'(i);
    end
    prog_n = 0;
  endtask

  task automatic emit(input logic [31:0] w, input int gap);
    prog[prog_n] = w;
    prog_n++;
    for (int i = 0; i < gap; i++) begin
      prog[prog_n] = 32'd0;
      prog_n++;
    end
  endtask

  // sequential instruction-set model of the program
  task automatic model_run();
    logic [31:0] rf [32];
    logic [31:0] dm [WORDS];
    logic [31:0] pc, ir, a, b, imm, ea;
    for (int i = 0; i < 32; i++) rf[i] = 32'd0;
    for (int i = 0; i < WORDS; i++) dm[i] = dinit[i];
    pc = 32'd0;
    exp_n = 0;
    for (int step = 0; step < 2000; step++) begin
      ir  = prog[pc[9:2]];
      a   = rf[ir[10:6]];
      b   = rf[ir[15:11]];
      imm = {{16{ir[15]}}, ir[15:0]};
      ea  = a + imm;
      case (ir[31:26])
        6'd1, 6'd2, 6'd3, 6'd4: begin
          exp_rd[exp_n] = ir[20:16];
          case (ir[31:26])
            6'd1: exp_data[exp_n] = a + b;
            6'd2: exp_data[exp_n] = a - b;
            6'd3: exp_data[exp_n] = a & b;
            default: exp_data[exp_n] = a | b;
          endcase
        end
        6'd5: begin exp_rd[exp_n] = ir[15:11]; exp_data[exp_n] = ea; end
        6'd6: begin exp_rd[exp_n] = ir[15:11]; exp_data[exp_n] = dm[ea[9:2]]; end
        6'd7: dm[ea[9:2]] = b;
        default: ;
      endcase
      if (ir[31:26] inside {6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6}) begin
        if (exp_rd[exp_n] != 5'd0) rf[exp_rd[exp_n]] = exp_data[exp_n];
        exp_n++;
      end
      if (ir[31:26] == 6'd8 && a == b) begin
        if (imm == 32'd0) break;
        pc = pc + imm;
      end else begin
        pc = pc + 32'd4;
      end
    end
  endtask

  task automatic load_and_hold();
    rst = 1'b1;
    for (int i = 0; i < 2 * WORDS; i++) begin
      @(negedge clk);
      ld_en   = 1'b1;
      ld_dmem = (i >= WORDS);
      ld_addr = 8'(i % WORDS);
      ld_data = (i >= WORDS) ? dinit[i - WORDS] : prog[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_prog(input string req, input int cycles);
    int obs;
    model_run();
    load_and_hold();
    obs = 0;
    first_wc = -1;
    pc_at3 = 32'hx;
    rst = 1'b0;
    for (int c = 1; c <= cycles; c++) begin
      @(negedge clk);
      if (c == 3) pc_at3 = dbg_pc;
      if (dbg_wb_we) begin
        if (first_wc < 0) first_wc = c;
        if (obs < exp_n) begin
          chk(dbg_wb_rd == exp_rd[obs], req, "write destination (R11)",
              32'(dbg_wb_rd), 32'(exp_rd[obs]));
          chk(dbg_wb_data == exp_data[obs], req, "write data (R11)",
              dbg_wb_data, exp_data[obs]);
        end else begin
          chk(1'b0, req, "unexpected extra write (R11)", 32'(obs), 32'(exp_n));
        end
        obs++;
      end
    end
    chk(obs == exp_n, req, "number of retired writes", 32'(obs), 32'(exp_n));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    clear_prog();
    emit(ri(6'd5, 5'd1, 5'd0, 6'd3), 2);
    emit(HALT, 0);
    load_and_hold();
    chk(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
    chk(dbg_wb_we == 1'b0, "R1", "write enable in reset", 32'(dbg_wb_we), 32'd0);
  endtask

  task automatic t_timing();
    clear_prog();
    emit(ri(6'd5, 5'd1, 5'd0, 6'd7), 0);
    emit(ri(6'd5, 5'd2, 5'd0, 6'd9), 2);
    emit(HALT, 0);
    run_prog("R2", prog_n + 20);
    chk(pc_at3 == 32'd12, "R2", "pc after three edges", pc_at3, 32'd12);
    chk(first_wc == 4, "R2", "edge of first write", 32'(first_wc), 32'd4);
  endtask

  task automatic t_alu();
    clear_prog();
    emit(ri(6'd5, 5'd1, 5'd0, 6'd5), 0);   // r1 = 0x805
    emit(ri(6'd5, 5'd2, 5'd0, 6'd9), 2);   // r2 = 0x1009
    emit(rr(6'd1, 5'd3, 5'd1, 5'd2), 0);   // R4 add
    emit(rr(6'd2, 5'd4, 5'd1, 5'd2), 0);   // R4 sub, negative
    emit(rr(6'd3, 5'd5, 5'd1, 5'd2), 0);   // R4 and
    emit(rr(6'd4, 5'd6, 5'd1, 5'd2), 0);   // R4 or
    emit(rr(6'h3F, 5'd7, 5'd1, 5'd2), 0);  // R3 unknown opcode, no write
    emit(rr(6'h09, 5'd8, 5'd1, 5'd2), 0);  // R3 unknown opcode, no write
    emit(HALT, 0);
    run_prog("R3/R4", prog_n + 20);
  endtask

  task automatic t_addi();
    clear_prog();
    emit(ri(6'd5, 5'd17, 5'd0, 6'd1), 2);  // R5 negative immediate
    emit(ri(6'd5, 5'd3, 5'd17, 6'd63), 2); // R5 base from register
    emit(ri(6'd5, 5'd20, 5'd3, 6'd0), 2);
    emit(HALT, 0);
    run_prog("R5", prog_n + 20);
  endtask

  task automatic t_r0();
    clear_prog();
    emit(ri(6'd5, 5'd0, 5'd0, 6'd33), 0);  // R9 write to r0 retires but is dropped
    emit(ri(6'd5, 5'd1, 5'd0, 6'd4), 2);
    emit(rr(6'd1, 5'd8, 5'd0, 5'd0), 0);   // R9 r0 + r0 reads zero
    emit(rr(6'd4, 5'd9, 5'd0, 5'd1), 0);
    emit(HALT, 0);
    run_prog("R9", prog_n + 20);
  endtask

  task automatic t_ldst();
    clear_prog();
    dinit[3] = 32'hDEAD_BEEF;
    emit(ri(6'd6, 5'd9, 5'd0, 6'd12), 2);  // R6 load word 3
    emit(ri(6'd7, 5'd9, 5'd0, 6'd40), 2);  // R6 store r9 to word 10
    emit(ri(6'd6, 5'd10, 5'd0, 6'd40), 2); // R6 read it back
    emit(ri(6'd5, 5'd1, 5'd0, 6'd8), 2);   // r1 base
    emit(ri(6'd6, 5'd11, 5'd1, 6'd4), 2);  // R6 base plus offset, wraps
    emit(ri(6'd7, 5'd1, 5'd1, 6'd0), 2);   // R6 store with register base
    emit(ri(6'd6, 5'd12, 5'd1, 6'd0), 2);
    emit(HALT, 0);
    run_prog("R6", prog_n + 20);
  endtask

  task automatic t_branch_taken();
    clear_prog();
    emit(ri(6'd5, 5'd1, 5'd0, 6'd2), 2);
    emit(ri(6'd8, 5'd0, 5'd0, 6'd24), 0);  // R7 taken, skip 5 words
    emit(ri(6'd7, 5'd1, 5'd0, 6'd20), 0);  // R7 cancelled store to word 5
    emit(ri(6'd5, 5'd2, 5'd0, 6'd1), 0);   // R7 cancelled writes
    emit(ri(6'd5, 5'd3, 5'd0, 6'd1), 0);
    emit(ri(6'd5, 5'd4, 5'd0, 6'd1), 0);
    emit(ri(6'd5, 5'd5, 5'd0, 6'd1), 0);
    emit(ri(6'd6, 5'd6, 5'd0, 6'd20), 2);  // load word 5: must be unchanged
    emit(rr(6'd1, 5'd7, 5'd1, 5'd2), 2);   // r2 still zero
    emit(ri(6'd8, 5'd1, 5'd1, 6'd0), 0);   // R7 taken r1==r1, wraps +16 words
    emit(ri(6'd5, 5'd8, 5'd0, 6'd1), 0);
    emit(ri(6'd5, 5'd9, 5'd0, 6'd1), 0);
    emit(ri(6'd5, 5'd10, 5'd0, 6'd1), 0);
    for (int i = prog_n; i < 34; i++) emit(32'd0, 0);
    emit(ri(6'd5, 5'd11, 5'd0, 6'd3), 0);
    emit(HALT, 0);
    run_prog("R7", prog_n + 30);
  endtask

  task automatic t_branch_not_taken();
    clear_prog();
    emit(ri(6'd5, 5'd1, 5'd0, 6'd1), 2);
    emit(ri(6'd8, 5'd0, 5'd1, 6'd8), 0);   // R8 r1 != r0, falls through
    emit(ri(6'd5, 5'd2, 5'd0, 6'd2), 0);
    emit(ri(6'd5, 5'd3, 5'd0, 6'd3), 0);
    emit(ri(6'd5, 5'd4, 5'd0, 6'd4), 0);
    emit(HALT, 0);
    run_prog("R8", prog_n + 20);
  endtask

  task automatic t_same_cycle();
    clear_prog();
    emit(ri(6'd5, 5'd1, 5'd0, 6'd11), 2);  // exactly two no-ops
    emit(rr(6'd1, 5'd2, 5'd1, 5'd1), 2);   // R10 sees new r1
    emit(ri(6'd6, 5'd3, 5'd0, 6'd0), 2);
    emit(rr(6'd2, 5'd4, 5'd3, 5'd2), 0);   // R10 sees loaded r3
    emit(HALT, 0);
    run_prog("R10", prog_n + 20);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_timing();
    t_alu();
    t_addi();
    t_r0();
    t_ldst();
    t_branch_taken();
    t_branch_not_taken();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule